// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting channel of a programmable interval timer. A register front end outside the block hands it a mode code and a binary/decimal select through a mode-write strobe. It hands over the initial count through a count-write strobe, issued once the last byte of that count has arrived. The channel then drives a single output waveform, shaped by the selected mode and by the level and edges of its gate input.

The six modes are: a level that rises at terminal count, a gate-triggered retriggerable one-shot, a periodic rate generator with a one-clock low pulse, a square wave, a strobe started by writing the count, and a strobe started by a gate rising edge. In the aperiodic modes the counter wraps to its maximum at zero. In the periodic modes it reloads from the stored initial count. In decimal mode the counter holds four BCD digits and borrows digit by digit. The live count is always visible on an output port. The counter decrements on every rising clock edge in which counting is enabled.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the output is low, the live count is zero, the selected mode is 0 in binary, and the counter does not move until a count is written.
- R2: In mode 0 the output goes low on a mode write or a count write. The count is loaded on the edge that samples the count-write strobe. The output goes high on the edge at which the count reaches zero and stays high until the next write.
- R3: In mode 1 the output is high after the mode write. A gate rising edge loads the stored count and drives the output low. The output returns high when the count reaches zero. A new gate rising edge reloads the count and drives the output low again.
- R4: In mode 2 with an initial count N of at least 2, the output is low for exactly the one clock in which the count equals 1. On the next edge the counter reloads N, so the period is N clocks.
- R5: In mode 3 the output is high while the count is above half the initial count N and low otherwise, and the counter reloads after 1. This gives (N+1)/2 high clocks and (N-1)/2 low clocks for odd N, and N/2 of each for even N.
- R6: In mode 4 writing the count starts counting. The output is low for one clock when the count reaches zero. The counter wraps and keeps counting without a second strobe until the count is written again.
- R7: In mode 5 a gate rising edge loads the stored count. The output is low for one clock when the count reaches zero.
- R8: A low gate freezes the count in modes 0, 2, 3 and 4. In modes 2 and 3 a low gate also drives the output high on the next edge.
- R9: In modes 0, 1, 4 and 5 a count of zero decrements to 0xFFFF in binary or to 0x9999 (decimal 9999) in BCD.
- R10: With the decimal select set to 1, the count holds four BCD digits, least significant digit in bits 3:0. A decrement borrows across digits, so 0x1000 becomes 0x0999.
- R11: An initial count of zero lasts 65536 clocks in binary and 10000 clocks in BCD.
- R12: Mode codes 0 to 5 on the 3-bit mode select choose modes 0 to 5. Codes 6 and 7 act as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Gate level: enables counting or triggers a load, depending on the mode |
| mode_wr | input | 1 | Strobe: accept mode_sel and bcd_sel |
| mode_sel | input | 3 | Mode code |
| bcd_sel | input | 1 | 1 selects four-digit BCD counting |
| cnt_wr | input | 1 | Strobe: the complete initial count is on cnt_val |
| cnt_val | input | CW | Initial count |
| tmr_out | output | 1 | Channel output waveform |
| cnt_now | output | CW | Live count |

## Verification
The bench builds the channel with the default 16-bit count width, which gives four BCD digits. With this width the full binary zero-count run of 65536 clocks and the decimal run of 10000 clocks both fit within the bench's run time. The same width lets the decimal wrap to 9999 and a full second pass through zero in mode 4 be watched clock by clock, to confirm that no second strobe appears. The short counts of 3, 4 and 5 bring every per-clock edge of the periodic waveforms, both odd and even half splits, and the gate freeze into a few dozen clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_TC      = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmr_mode_e;

  // codes 6 and 7 fold onto the two periodic modes
  function automatic tmr_mode_e mode_decode(input logic [2:0] code);
    case (code)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return tmr_mode_e'(code);
    endcase
  endfunction

endpackage

// File: rtl/tmr_bcd_dec.sv
module tmr_bcd_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         bcd,
  output logic [W-1:0] dec
);
  localparam int ND = W / 4;

  logic [ND-1:0] brw;
  logic [W-1:0]  bcd_res;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [3:0] d;
    assign d = cur[g*4 +: 4];
    assign bcd_res[g*4 +: 4] = !brw[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (g < ND - 1) begin : g_chain
      assign brw[g+1] = brw[g] && (d == 4'd0);
    end
  end

  assign dec = bcd ? bcd_res : cur - W'(1);
endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate && !gate_q;
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic          mode_wr,
  input  logic [2:0]    mode_sel,
  input  logic          bcd_sel,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_val,
  output logic          tmr_out,
  output logic [CW-1:0] cnt_now
);
  localparam int ND = CW / 4;
  localparam logic [CW-1:0] BCD_MAX = {ND{4'h9}};

  // threshold below which the square wave is low, in the count's own encoding
  function automatic logic [CW-1:0] half_pt(input logic [CW-1:0] v, input logic b);
    int unsigned n;
    logic [CW-1:0] r;
    r = '0;
    if (!b) begin
      r = (v == '0) ? {1'b1, {(CW-1){1'b0}}} : (v >> 1);
    end else begin
      n = 0;
      for (int i = ND - 1; i >= 0; i--) n = n * 10 + 32'(v[i*4 +: 4]);
      if (n == 0) begin
        n = 1;
        for (int i = 0; i < ND; i++) n = n * 10;
      end
      n = n / 2;
      for (int i = 0; i < ND; i++) begin
        r[i*4 +: 4] = 4'(n % 10);
        n = n / 10;
      end
    end
    return r;
  endfunction

  tmr_mode_e     mode_q, mode_in;
  logic          bcd_q, run_q, fired_q, out_q;
  logic [CW-1:0] init_q, cnt_q, dec_v, nxt, half_v;
  logic          gate_rise, periodic, trig_mode, cnt_en;
  logic          trig_load, step, tc_next, above_half, wrap_evt;

  tmr_bcd_dec #(.W(CW)) u_dec (.cur(cnt_q), .bcd(bcd_q), .dec(dec_v));
  tmr_gate_edge u_edge (.clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise));

  assign mode_in    = mode_decode(mode_sel);
  assign periodic   = (mode_q == M_RATE) || (mode_q == M_SQUARE);
  assign trig_mode  = (mode_q == M_ONESHOT) || (mode_q == M_HWSTB);
  assign cnt_en     = trig_mode ? 1'b1 : gate;
  assign trig_load  = gate_rise && trig_mode && !mode_wr && !cnt_wr;
  assign step       = run_q && cnt_en && !mode_wr && !cnt_wr && !trig_load;
  assign nxt        = (periodic && cnt_q == CW'(1)) ? init_q : dec_v;
  assign tc_next    = (nxt == '0);
  assign half_v     = half_pt(init_q, bcd_q);
  assign above_half = (nxt == '0) || (nxt > half_v);
  assign wrap_evt   = step && !periodic && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_TC;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      out_q   <= 1'b0;
    end else if (mode_wr) begin
      mode_q  <= mode_in;
      bcd_q   <= bcd_sel;
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      out_q   <= (mode_in != M_TC);
    end else if (cnt_wr) begin
      init_q  <= cnt_val;
      fired_q <= 1'b0;
      if (!trig_mode) begin
        cnt_q <= cnt_val;
        run_q <= 1'b1;
        out_q <= (mode_q != M_TC);
      end
    end else if (trig_load) begin
      cnt_q   <= init_q;
      run_q   <= 1'b1;
      fired_q <= 1'b0;
      out_q   <= (mode_q != M_ONESHOT);
    end else if (step) begin
      cnt_q <= nxt;
      case (mode_q)
        M_TC, M_ONESHOT: out_q <= out_q | tc_next;
        M_RATE:          out_q <= (nxt != CW'(1));
        M_SQUARE:        out_q <= above_half;
        default: begin
          out_q <= !(tc_next && !fired_q);
          if (tc_next) fired_q <= 1'b1;
        end
      endcase
    end else if (run_q && periodic && !gate) begin
      out_q <= 1'b1;
    end
  end

  assign tmr_out = out_q;
  assign cnt_now = cnt_q;

  // R9
  wrap_to_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == (bcd_q ? BCD_MAX : '1)));

  // R2
  tc_level_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TC && $fell(out_q)) |-> $past(mode_wr || cnt_wr));

  // R4
  rate_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && run_q && !out_q && init_q != CW'(1) && !mode_wr) |=> out_q);

  // R8
  gate_low_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && periodic && !gate && !mode_wr && !cnt_wr) |=> out_q);

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SWSTB && fired_q && !mode_wr && !cnt_wr) |=> out_q);
endmodule

// File: tb/sim_interval_timer_chan.sv
module sim_interval_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate = 1'b0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        bcd_sel = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_val = 16'd0;
  logic        tmr_out;
  logic [15:0] cnt_now;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  interval_timer_chan #(.CW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .gate(gate), .mode_wr(mode_wr),
    .mode_sel(mode_sel), .bcd_sel(bcd_sel), .cnt_wr(cnt_wr),
    .cnt_val(cnt_val), .tmr_out(tmr_out), .cnt_now(cnt_now)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [2:0] m, input logic b);
    mode_sel = m; bcd_sel = b; mode_wr = 1'b1;
    tick();
    mode_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_val = v; cnt_wr = 1'b1;
    tick();
    cnt_wr = 1'b0;
  endtask

  // model decrement: decimal arithmetic on digit values, or plain binary
  function automatic logic [15:0] mdec(input logic [15:0] v, input bit b);
    int n;
    logic [15:0] r;
    if (!b) return v - 16'd1;
    n = v[15:12] * 1000 + v[11:8] * 100 + v[7:4] * 10 + v[3:0];
    n = (n + 9999) % 10000;
    r = {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    chk("R1 out after reset", 32'(tmr_out), 0);
    chk("R1 count after reset", 32'(cnt_now), 0);
  endtask

  task automatic t_mode0();
    gate = 1'b1;
    wr_mode(3'd0, 1'b0);
    wr_cnt(16'd5);
    chk("R2 load", 32'(cnt_now), 5);
    chk("R2 low after load", 32'(tmr_out), 0);
    repeat (4) tick();
    chk("R2 count 1", 32'(cnt_now), 1);
    chk("R2 still low", 32'(tmr_out), 0);
    tick();
    chk("R2 high at zero", 32'(tmr_out), 1);
    tick();
    chk("R9 binary wrap", 32'(cnt_now), 32'hFFFF);
    chk("R2 stays high", 32'(tmr_out), 1);
    gate = 1'b0;
    tick(); tick();
    chk("R8 mode0 frozen", 32'(cnt_now), 32'hFFFF);
    gate = 1'b1;
    wr_cnt(16'd3);
    chk("R2 new count low", 32'(tmr_out), 0);
  endtask

  task automatic t_mode1();
    gate = 1'b0;
    wr_mode(3'd1, 1'b0);
    chk("R3 high after mode", 32'(tmr_out), 1);
    wr_cnt(16'd4);
    tick();
    chk("R3 waits for trigger", 32'(tmr_out), 1);
    gate = 1'b1;
    tick();
    chk("R3 trigger load", 32'(cnt_now), 4);
    chk("R3 low after trigger", 32'(tmr_out), 0);
    repeat (3) tick();
    chk("R3 low before zero", 32'(tmr_out), 0);
    tick();
    chk("R3 high at zero", 32'(tmr_out), 1);
    tick();
    chk("R9 wrap mode1", 32'(cnt_now), 32'hFFFF);
    gate = 1'b0; tick();
    gate = 1'b1; tick();
    tick(); tick();
    chk("R3 count 2", 32'(cnt_now), 2);
    gate = 1'b0; tick();
    gate = 1'b1; tick();
    chk("R3 retrigger reload", 32'(cnt_now), 4);
    chk("R3 retrigger low", 32'(tmr_out), 0);
  endtask

  task automatic t_mode2();
    logic [15:0] ec;
    gate = 1'b1;
    wr_mode(3'd2, 1'b0);
    wr_cnt(16'd4);
    ec = 16'd4;
    for (int i = 0; i < 10; i++) begin
      chk("R4 count", 32'(cnt_now), 32'(ec));
      chk("R4 out", 32'(tmr_out), 32'(ec != 16'd1));
      tick();
      ec = (ec == 16'd1) ? 16'd4 : ec - 16'd1;
    end
    while (ec != 16'd1) begin
      tick();
      ec = ec - 16'd1;
    end
    chk("R4 low at 1", 32'(tmr_out), 0);
    gate = 1'b0;
    tick();
    chk("R8 forced high", 32'(tmr_out), 1);
    chk("R8 mode2 frozen", 32'(cnt_now), 1);
    gate = 1'b1;
    tick();
    chk("R4 reload after resume", 32'(cnt_now), 4);
  endtask

  task automatic t_square(input int n);
    logic [15:0] ec;
    int highs;
    gate = 1'b1;
    wr_mode(3'd3, 1'b0);
    wr_cnt(16'(n));
    ec = 16'(n);
    highs = 0;
    for (int i = 0; i < 2 * n; i++) begin
      chk("R5 count", 32'(cnt_now), 32'(ec));
      chk("R5 out", 32'(tmr_out), 32'(int'(ec) > n / 2));
      if (tmr_out) highs++;
      tick();
      ec = (ec == 16'd1) ? 16'(n) : ec - 16'd1;
    end
    chk("R5 high clocks", 32'(highs), 32'(2 * ((n + 1) / 2)));
  endtask

  task automatic t_mode4();
    int lows;
    gate = 1'b1;
    wr_mode(3'd4, 1'b1);
    wr_cnt(16'h0003);
    chk("R6 start on write", 32'(cnt_now), 3);
    chk("R6 high", 32'(tmr_out), 1);
    tick(); tick();
    chk("R6 high before zero", 32'(tmr_out), 1);
    tick();
    chk("R6 strobe low", 32'(tmr_out), 0);
    tick();
    chk("R6 strobe one clock", 32'(tmr_out), 1);
    chk("R9 BCD wrap", 32'(cnt_now), 32'h9999);
    lows = 0;
    for (int i = 0; i < 10000; i++) begin
      tick();
      if (!tmr_out) lows++;
    end
    chk("R6 no second strobe", 32'(lows), 0);
    chk("R6 counting continued", 32'(cnt_now), 32'h9999);
  endtask

  task automatic t_mode5();
    gate = 1'b0;
    wr_mode(3'd5, 1'b0);
    wr_cnt(16'd3);
    chk("R7 high idle", 32'(tmr_out), 1);
    gate = 1'b1;
    tick();
    chk("R7 gate load", 32'(cnt_now), 3);
    tick(); tick();
    chk("R7 high before zero", 32'(tmr_out), 1);
    tick();
    chk("R7 strobe low", 32'(tmr_out), 0);
    tick();
    chk("R7 strobe one clock", 32'(tmr_out), 1);
  endtask

  task automatic t_bcd();
    logic [15:0] ev;
    gate = 1'b1;
    wr_mode(3'd0, 1'b1);
    wr_cnt(16'h1000);
    ev = 16'h1000;
    for (int i = 0; i < 3; i++) begin
      tick();
      ev = mdec(ev, 1'b1);
      chk("R10 BCD borrow", 32'(cnt_now), 32'(ev));
    end
    wr_cnt(16'h0010);
    tick();
    chk("R10 BCD digit borrow", 32'(cnt_now), 32'h0009);
  endtask

  task automatic t_zero(input bit b, input int expect_n);
    int n;
    gate = 1'b1;
    wr_mode(3'd0, b);
    wr_cnt(16'd0);
    n = 0;
    while (!tmr_out && n < 70000) begin
      tick();
      n++;
    end
    chk("R11 zero count length", 32'(n), 32'(expect_n));
  endtask

  task automatic t_alias();
    gate = 1'b1;
    wr_mode(3'd6, 1'b0);
    wr_cnt(16'd3);
    tick(); tick();
    chk("R12 code6 rate pulse", 32'(tmr_out), 0);
    tick();
    chk("R12 code6 reload", 32'(cnt_now), 3);
    wr_mode(3'd7, 1'b0);
    wr_cnt(16'd4);
    chk("R12 code7 high", 32'(tmr_out), 1);
    tick(); tick();
    chk("R12 code7 low half", 32'(tmr_out), 0);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_square(5);
    t_square(4);
    t_mode4();
    t_mode5();
    t_bcd();
    t_zero(1'b1, 10000);
    t_zero(1'b0, 65536);
    t_alias();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule